// File: doc/BRIEF.md
# Arcade cartridge bank-switching mapper

This block is the address decoder and bank logic for an arcade-style game cartridge that holds up to six program ROM sockets and two character ROM sockets. It has no register of its own. It watches CPU writes to the controller strobe port at `$4016` and keeps bit 2 of the written value as a single bank-select bit. That one bit switches the low 8 KiB program window and the 8 KiB character window together. The upper 24 KiB of program space is fixed.

The block also decodes a 2 KiB work RAM at `$6000-$7FFF`. That RAM is enabled only while the grant input says this CPU owns it. Nametable accesses are passed through unbanked, as four separate screens.

Socket population is a parameter. A decoded socket that is not populated raises no chip enable, and the matching data-valid output drops low, so the access reads as open bus instead of mirrored data.

Top module: `cart_bank_mapper`

## Requirements
- R1: The bank-select bit is 0 after reset. A CPU write (`cpu_wr`=1) to exactly `$4016` loads data bit 2 into it on the next rising clock edge.
- R2: Data bits 0 and 1 of a `$4016` write do not affect the bank bit. Writes to any other address, including `$4017`, leave the bank bit unchanged.
- R3: A CPU read in `$8000-$9FFF` enables program socket 0 when the bank bit is 0 and socket 4 when it is 1. `prg_addr` carries `cpu_addr[12:0]`.
- R4: CPU reads in `$A000-$BFFF`, `$C000-$DFFF` and `$E000-$FFFF` enable program sockets 1, 2 and 3 respectively, whatever the bank bit holds.
- R5: A PPU access in `$0000-$1FFF` enables character socket 0 when the bank bit is 0 and socket 1 when it is 1. `chr_addr` carries `ppu_addr[12:0]`.
- R6: A CPU access in `$6000-$7FFF` raises `ram_ce` only while `ram_grant` is 1, with `ram_addr` = `cpu_addr[10:0]`. Reads without the grant leave `cpu_valid` low.
- R7: A socket whose bit in `PRG_POP`/`CHR_POP` is 0 is never enabled, and its reads leave the valid output low. Program socket 5 is never decoded.
- R8: PPU accesses in `$2000-$3EFF` raise `nt_ce`, with `nt_page` = `ppu_addr[11:10]` (four-screen), independent of the bank bit.
- R9: CPU writes to `$8000-$FFFF` enable no program socket, leave `cpu_valid` low and do not change the bank bit.
- R10: CPU accesses outside the RAM and ROM windows enable nothing and leave `cpu_valid` low. PPU accesses at `$3F00-$3FFF` enable nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe (0 = read) |
| ram_grant | input | 1 | This CPU currently owns the work RAM |
| ppu_addr | input | 14 | PPU address |
| bank_sel | output | 1 | Latched bank-select bit |
| prg_ce | output | 6 | Program socket chip enables, one per socket |
| prg_addr | output | 13 | Address inside the selected 8 KiB program socket |
| ram_ce | output | 1 | Work RAM enable |
| ram_addr | output | 11 | Work RAM address |
| cpu_valid | output | 1 | A populated device drives the CPU read data |
| chr_ce | output | 2 | Character socket chip enables |
| chr_addr | output | 13 | Address inside the selected character socket |
| ppu_valid | output | 1 | A populated character socket drives PPU read data |
| nt_ce | output | 1 | Nametable RAM enable |
| nt_page | output | 2 | Nametable page (four-screen) |

## Verification
The assertions assume that `cpu_wr` and `cpu_addr` are stable around the rising clock edge. They also assume that `ram_grant` comes from outside and is simply obeyed, with no ordering between grant changes and accesses. The stimulus changes every input only on the falling edge and holds it through the next rising edge. Sweep writes never land on `$4016`, so the bank bit changes only through deliberate writes. The bench then checks that it stayed put after each sweep. Both grant values and both bank values are crossed with reads and writes over the whole CPU and PPU maps.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
  localparam int PRG_SOCKETS = 6;
  localparam int CHR_SOCKETS = 2;
  localparam int CPU_AW      = 16;
  localparam int PPU_AW      = 14;
  localparam int WIN_AW      = 13;
  localparam int RAM_AW      = 11;
  localparam int DATA_W      = 8;
  localparam int SEL_BIT     = 2;
  localparam logic [CPU_AW-1:0] BANK_PORT = 16'h4016;
  localparam int ALT_SOCKET  = 4;

  // 8 KiB CPU windows, indexed by cpu_addr[15:13]
  typedef enum logic [2:0] {
    WIN_LOW0 = 3'd0, WIN_LOW1 = 3'd1, WIN_LOW2 = 3'd2, WIN_RAM = 3'd3,
    WIN_SW   = 3'd4, WIN_FIX1 = 3'd5, WIN_FIX2 = 3'd6, WIN_FIX3 = 3'd7
  } cpu_win_e;
endpackage

// File: rtl/bank_latch.sv
module bank_latch
  import cart_map_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CPU_AW-1:0] addr,
  input  logic              sel_in,
  output logic              rst_n_sync,
  output logic              bank_q
);
  logic [1:0] rst_pipe;
  logic       load;
  logic       bank_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  always_comb begin
    load   = wr_en && (addr == BANK_PORT);
    bank_d = sel_in;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)  bank_q <= 1'b0;
    else if (load)    bank_q <= bank_d;
  end

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wr_en && addr == BANK_PORT) |=> (bank_q == $past(sel_in))); // R1
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !(wr_en && addr == BANK_PORT) |=> $stable(bank_q)); // R2
endmodule

// File: rtl/prg_decode.sv
module prg_decode
  import cart_map_pkg::*;
#(
  parameter logic [PRG_SOCKETS-1:0] PRG_POP = 6'b011111
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CPU_AW-1:0]      addr,
  input  logic                   wr,
  input  logic                   bank,
  input  logic                   grant,
  output logic [PRG_SOCKETS-1:0] prg_ce,
  output logic [WIN_AW-1:0]      prg_addr,
  output logic                   ram_ce,
  output logic [RAM_AW-1:0]      ram_addr,
  output logic                   valid
);
  cpu_win_e               win;
  logic [PRG_SOCKETS-1:0] sock_sel;

  always_comb begin
    win      = cpu_win_e'(addr[CPU_AW-1:WIN_AW]);
    sock_sel = '0;
    unique case (win)
      WIN_SW:   sock_sel[bank ? ALT_SOCKET : 0] = 1'b1;
      WIN_FIX1: sock_sel[1] = 1'b1;
      WIN_FIX2: sock_sel[2] = 1'b1;
      WIN_FIX3: sock_sel[3] = 1'b1;
      default:  sock_sel = '0;
    endcase
  end

  for (genvar s = 0; s < PRG_SOCKETS; s++) begin : g_sock
    if (PRG_POP[s]) begin : g_pop
      assign prg_ce[s] = sock_sel[s] && !wr;
    end else begin : g_empty
      assign prg_ce[s] = 1'b0;
    end
  end

  assign prg_addr = addr[WIN_AW-1:0];
  assign ram_ce   = (win == WIN_RAM) && grant;
  assign ram_addr = addr[RAM_AW-1:0];
  assign valid    = !wr && ((|prg_ce) || ram_ce);

  AST_PRG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(prg_ce)); // R7
  AST_RAM_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    ram_ce |-> grant); // R6
  AST_ROM_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> (prg_ce == '0 && !valid)); // R9
  AST_FIXED_IGNORES_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && addr[CPU_AW-1:WIN_AW] == 3'd7) |-> (prg_ce[3] == PRG_POP[3])); // R4
endmodule

// File: rtl/chr_decode.sv
module chr_decode
  import cart_map_pkg::*;
#(
  parameter logic [CHR_SOCKETS-1:0] CHR_POP = 2'b01
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PPU_AW-1:0]      addr,
  input  logic                   bank,
  output logic [CHR_SOCKETS-1:0] chr_ce,
  output logic [WIN_AW-1:0]      chr_addr,
  output logic                   valid,
  output logic                   nt_ce,
  output logic [1:0]             nt_page
);
  logic                   pattern_hit;
  logic [CHR_SOCKETS-1:0] demux;

  always_comb begin
    pattern_hit  = !addr[PPU_AW-1];
    demux        = '0;
    demux[bank]  = pattern_hit;
  end

  for (genvar s = 0; s < CHR_SOCKETS; s++) begin : g_chr
    if (CHR_POP[s]) begin : g_pop
      assign chr_ce[s] = demux[s];
    end else begin : g_empty
      assign chr_ce[s] = 1'b0;
    end
  end

  assign chr_addr = addr[WIN_AW-1:0];
  assign valid    = |chr_ce;
  assign nt_ce    = addr[PPU_AW-1] && (addr[PPU_AW-1:8] != 6'h3F);
  assign nt_page  = addr[11:10];

  AST_CHR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chr_ce)); // R5
  AST_CHR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pattern_hit && !CHR_POP[bank]) |-> !valid); // R7
  AST_NT_APART: assert property (@(posedge clk) disable iff (!rst_n)
    nt_ce |-> (chr_ce == '0)); // R8
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cart_map_pkg::*;
#(
  parameter logic [PRG_SOCKETS-1:0] PRG_POP = 6'b011111,
  parameter logic [CHR_SOCKETS-1:0] CHR_POP = 2'b01
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CPU_AW-1:0]      cpu_addr,
  input  logic [DATA_W-1:0]      cpu_wdata,
  input  logic                   cpu_wr,
  input  logic                   ram_grant,
  input  logic [PPU_AW-1:0]      ppu_addr,
  output logic                   bank_sel,
  output logic [PRG_SOCKETS-1:0] prg_ce,
  output logic [WIN_AW-1:0]      prg_addr,
  output logic                   ram_ce,
  output logic [RAM_AW-1:0]      ram_addr,
  output logic                   cpu_valid,
  output logic [CHR_SOCKETS-1:0] chr_ce,
  output logic [WIN_AW-1:0]      chr_addr,
  output logic                   ppu_valid,
  output logic                   nt_ce,
  output logic [1:0]             nt_page
);
  logic rst_n_sync;
  logic unused_wdata;

  assign unused_wdata = ^{cpu_wdata[DATA_W-1:SEL_BIT+1], cpu_wdata[SEL_BIT-1:0]};

  bank_latch i_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cpu_wr),
    .addr       (cpu_addr),
    .sel_in     (cpu_wdata[SEL_BIT]),
    .rst_n_sync (rst_n_sync),
    .bank_q     (bank_sel)
  );

  prg_decode #(.PRG_POP(PRG_POP)) i_prg (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .addr     (cpu_addr),
    .wr       (cpu_wr),
    .bank     (bank_sel),
    .grant    (ram_grant),
    .prg_ce   (prg_ce),
    .prg_addr (prg_addr),
    .ram_ce   (ram_ce),
    .ram_addr (ram_addr),
    .valid    (cpu_valid)
  );

  chr_decode #(.CHR_POP(CHR_POP)) i_chr (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .addr     (ppu_addr),
    .bank     (bank_sel),
    .chr_ce   (chr_ce),
    .chr_addr (chr_addr),
    .valid    (ppu_valid),
    .nt_ce    (nt_ce),
    .nt_page  (nt_page)
  );
endmodule

// File: tb/test_cart_bank_mapper.sv
module test_cart_bank_mapper;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] PRG_POP = 6'b011111;
  localparam logic [1:0] CHR_POP = 2'b01;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_wr;
  logic        ram_grant;
  logic [13:0] ppu_addr;
  logic        bank_sel;
  logic [5:0]  prg_ce;
  logic [12:0] prg_addr;
  logic        ram_ce;
  logic [10:0] ram_addr;
  logic        cpu_valid;
  logic [1:0]  chr_ce;
  logic [12:0] chr_addr;
  logic        ppu_valid;
  logic        nt_ce;
  logic [1:0]  nt_page;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_bank_mapper #(.PRG_POP(PRG_POP), .CHR_POP(CHR_POP)) i_cart_bank_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .ram_grant(ram_grant), .ppu_addr(ppu_addr),
    .bank_sel(bank_sel), .prg_ce(prg_ce), .prg_addr(prg_addr),
    .ram_ce(ram_ce), .ram_addr(ram_addr), .cpu_valid(cpu_valid),
    .chr_ce(chr_ce), .chr_addr(chr_addr), .ppu_valid(ppu_valid),
    .nt_ce(nt_ce), .nt_page(nt_page)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_addr = 16'h0000; cpu_wdata = 8'h00;
    #1;
  endtask

  function automatic logic [5:0] exp_prg(input logic [15:0] a, input logic w, input logic b);
    int s;
    if (w || !a[15]) return 6'b0;
    s = (a[14:13] == 2'd0) ? (b ? 4 : 0) : int'(a[14:13]);
    return PRG_POP[s] ? (6'b1 << s) : 6'b0;
  endfunction

  task automatic sweep_cpu(input logic b);
    for (int g = 0; g < 2; g++) begin
      for (int w = 0; w < 2; w++) begin
        for (int i = 0; i < 256; i++) begin
          logic [15:0] a;
          logic [5:0]  ep;
          logic        er;
          string       tag;
          a  = 16'((i << 8) | i);
          @(negedge clk);
          cpu_addr = a; cpu_wr = w[0]; ram_grant = g[0]; cpu_wdata = 8'hFF;
          #1;
          ep = exp_prg(a, w[0], b);
          er = (a[15:13] == 3'd3) && g[0];
          if (a[15] && w[0])             tag = "R9";
          else if (a[15:13] == 3'd4)     tag = "R3";
          else if (a[15])                tag = "R4";
          else if (a[15:13] == 3'd3)     tag = "R6";
          else                           tag = "R10";
          check(tag, {26'b0, prg_ce}, {26'b0, ep});
          check(tag, {31'b0, ram_ce}, {31'b0, er});
          check(tag, {31'b0, cpu_valid}, {31'b0, !w[0] && ((ep != 0) || er)});
          if (ep != 0) check("R3", {19'b0, prg_addr}, {19'b0, a[12:0]});
          if (er)      check("R6", {21'b0, ram_addr}, {21'b0, a[10:0]});
        end
      end
    end
    @(negedge clk);
    cpu_wr = 1'b0;
    #1;
    check("R2", {31'b0, bank_sel}, {31'b0, b});
  endtask

  task automatic sweep_ppu(input logic b);
    for (int i = 0; i < 256; i++) begin
      logic [13:0] p;
      logic [1:0]  ec;
      logic        en;
      @(negedge clk);
      p = 14'((i << 6) | (i & 6'h3F));
      ppu_addr = p;
      #1;
      ec = (!p[13] && CHR_POP[b]) ? (2'b1 << b) : 2'b0;
      en = p[13] && (p[13:8] != 6'h3F);
      if (!p[13]) begin
        check(b ? "R7" : "R5", {30'b0, chr_ce}, {30'b0, ec});
        check(b ? "R7" : "R5", {31'b0, ppu_valid}, {31'b0, ec != 0});
        if (ec != 0) check("R5", {19'b0, chr_addr}, {19'b0, p[12:0]});
      end else begin
        check(en ? "R8" : "R10", {30'b0, chr_ce}, 32'b0);
        check(en ? "R8" : "R10", {31'b0, nt_ce}, {31'b0, en});
        if (en) check("R8", {30'b0, nt_page}, {30'b0, p[11:10]});
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_wr = 1'b0;
    ram_grant = 1'b0; ppu_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset", {31'b0, bank_sel}, 32'b0);

    cpu_write(16'h4016, 8'h03);
    check("R2 low bits", {31'b0, bank_sel}, 32'b0);
    cpu_write(16'h4017, 8'h04);
    check("R2 other port", {31'b0, bank_sel}, 32'b0);
    cpu_write(16'h8000, 8'hFF);
    check("R9 rom write", {31'b0, bank_sel}, 32'b0);

    sweep_cpu(1'b0);
    sweep_ppu(1'b0);

    cpu_write(16'h4016, 8'h04);
    check("R1 set", {31'b0, bank_sel}, 32'b1);
    cpu_write(16'h4016, 8'hFF & ~8'h04 | 8'h04);
    check("R1 keep", {31'b0, bank_sel}, 32'b1);
    cpu_write(16'h4016, 8'h07 & 8'h07);
    check("R2 low bits set", {31'b0, bank_sel}, 32'b1);

    sweep_cpu(1'b1);
    sweep_ppu(1'b1);

    cpu_write(16'h4016, 8'hFB);
    check("R1 clear", {31'b0, bank_sel}, 32'b0);
    @(negedge clk);
    cpu_addr = 16'h9ABC; cpu_wr = 1'b0;
    #1;
    check("R3 back to 0", {26'b0, prg_ce}, 32'h1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule